// File: doc/BRIEF.md
# SDRAM Bank State Tracker

This block watches the command lines of a single-data-rate SDRAM and keeps an independent model of every bank on the device. On each clock it decodes chip select, the three strobe lines, the bank address and address bit 10. It then moves each bank through eight states: idle, opening (row activation pending), open (row active), read burst, write burst, closing (precharge pending), read burst with auto-close and write burst with auto-close. The opening, closing and auto-close states are timed by parameterised counters. Bursts without auto-close fall back to the open state when their length runs out.

Any command that a bank cannot accept in its present state is reported by a one-cycle pulse and the number of the offending bank, and it leaves that bank's state untouched. The block is meant as a protocol monitor beside a memory controller, or as a building block for one. The packed state of all banks is visible on an output at all times.

Top module: `sdram_bank_tracker`

## Requirements
- R1: Commands decode with CS# low and {RAS#,CAS#,WE#} as: 111 no-op, 011 open row, 001 auto refresh, 000 mode register load, 010 precharge, 101 read, 100 write, 110 burst stop. CS# high or the no-op code never flags and never changes a bank.
- R2: A command is evaluated only when CKE was high on the previous clock and is high on the current one. Otherwise it is ignored and never flagged.
- R3: An idle bank accepts open row, auto refresh, mode register load and precharge. Precharge leaves it idle, and auto refresh or mode register load leave it idle. Read, write and burst stop to an idle bank are flagged.
- R4: Open row moves the addressed bank to opening. Commands to it are refused for the next T_RCD-1 cycles, and it accepts a read issued exactly T_RCD cycles after the open.
- R5: An open bank accepts read, write and precharge. Open row, auto refresh, mode register load and burst stop to it are flagged.
- R6: During a read or write burst without auto-close, the bank accepts read, write, precharge and burst stop. Burst stop returns it to open. A new read or write restarts the burst. With no further command, the bank is open again BURST_LEN cycles after the burst began.
- R7: Precharge to a non-idle bank moves it to closing. It becomes idle so that open row is accepted exactly T_RP cycles after the precharge.
- R8: A10 high on read or write selects auto-close. The bank refuses every command until BURST_LEN+T_RP cycles after the command, and is idle from then on.
- R9: In opening, closing and both auto-close states, every command other than no-op to that bank is flagged.
- R10: Precharge with A10 high addresses all banks. Each bank accepts or refuses it on its own state, and the lowest refusing bank is reported.
- R11: After CKE goes from low to high, every non-no-op command issued within the next T_XSR-1 cycles is flagged, and commands are accepted again T_XSR cycles after the rising edge.
- R12: A refused command raises the illegal output for exactly the cycle after it, with illegal_bank holding its bank, and leaves that bank's state unchanged.
- R13: After reset all banks are idle (state code 0) and the illegal output is low.
- R14: bank_state holds bank b's state at bits [3b+2:3b], coded 0 idle, 1 opening, 2 open, 3 read, 4 write, 5 closing, 6 read auto-close, 7 write auto-close.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable line |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Address bit 10: auto-close or all-bank select |
| illegal | output | 1 | One-cycle pulse for a refused command |
| illegal_bank | output | BA_W | Bank of the refused command |
| bank_state | output | 3*2**BA_W | Packed per-bank state codes |

## Verification
Two events can coincide on one edge: a bank's timer runs out while a new command for that bank arrives. The command must be judged against the state held before the edge. The bench provokes this by issuing reads and opens exactly one cycle before and exactly at the tRCD, tRP and burst boundaries. A behavioural reference model tracks deadlines as absolute cycle numbers rather than down-counters, and it decides each command on the state the bank had when the command arrived. Its verdict and its view of every bank are compared on every clock, which also covers an all-bank precharge that meets banks in different states.

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker #(
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_XSR     = 8,
  parameter int BURST_LEN = 4,
  parameter int BA_W      = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cke,
  input  logic                      cs_n,
  input  logic                      ras_n,
  input  logic                      cas_n,
  input  logic                      we_n,
  input  logic [BA_W-1:0]           ba,
  input  logic                      a10,
  output logic                      illegal,
  output logic [BA_W-1:0]           illegal_bank,
  output logic [3*(1<<BA_W)-1:0]    bank_state
);
  localparam int NB = 1 << BA_W;
  localparam int CW = $clog2(T_RCD + T_RP + BURST_LEN + 1);
  localparam int XW = $clog2(T_XSR + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPENING, ST_OPEN, ST_RD, ST_WR, ST_CLOSING, ST_RD_AP, ST_WR_AP
  } bst_t;

  logic          cke_q;
  logic [XW-1:0] xs_cnt;
  logic [NB-1:0] bad;
  logic [BA_W-1:0] sel;

  wire [2:0] rcw = {ras_n, cas_n, we_n};
  wire run     = cke_q & cke;
  wire live    = run & ~cs_n & (rcw != 3'b111);
  wire c_act   = rcw == 3'b011;
  wire c_ref   = rcw == 3'b001;
  wire c_lmr   = rcw == 3'b000;
  wire c_pre   = rcw == 3'b010;
  wire c_rd    = rcw == 3'b101;
  wire c_wr    = rcw == 3'b100;
  wire c_bst   = rcw == 3'b110;
  wire xs_hold = xs_cnt != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke_q  <= 1'b1;
      xs_cnt <= '0;
    end else begin
      cke_q <= cke;
      if (!cke_q && cke) xs_cnt <= XW'(T_XSR - 1);
      else if (xs_hold)  xs_cnt <= xs_cnt - 1'b1;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    bst_t          st;
    logic [CW-1:0] cnt;
    logic          ok;

    wire hit   = live & ((ba == BA_W'(b)) | (c_pre & a10));
    assign bad[b] = hit & (xs_hold | ~ok);
    wire apply = hit & ~bad[b];
    wire timed = (st != ST_IDLE) && (st != ST_OPEN);

    always_comb begin
      case (st)
        ST_IDLE:      ok = c_act | c_ref | c_lmr | c_pre;
        ST_OPEN:      ok = c_rd | c_wr | c_pre;
        ST_RD, ST_WR: ok = c_rd | c_wr | c_pre | c_bst;
        default:      ok = 1'b0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st  <= ST_IDLE;
        cnt <= '0;
      end else if (apply) begin
        if (c_act) begin
          st  <= ST_OPENING;
          cnt <= CW'(T_RCD - 2);
        end else if (c_pre && st != ST_IDLE) begin
          st  <= ST_CLOSING;
          cnt <= CW'(T_RP - 2);
        end else if (c_rd || c_wr) begin
          st  <= a10 ? (c_rd ? ST_RD_AP : ST_WR_AP) : (c_rd ? ST_RD : ST_WR);
          cnt <= a10 ? CW'(BURST_LEN + T_RP - 2) : CW'(BURST_LEN - 2);
        end else if (c_bst) begin
          st <= ST_OPEN;
        end
      end else if (timed) begin
        if (cnt == '0)
          st <= (st == ST_OPENING || st == ST_RD || st == ST_WR) ? ST_OPEN : ST_IDLE;
        else
          cnt <= cnt - 1'b1;
      end
    end

    assign bank_state[3*b +: 3] = st;
  end

  always_comb begin
    sel = '0;
    for (int i = NB - 1; i >= 0; i--)
      if (bad[i]) sel = BA_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      illegal      <= 1'b0;
      illegal_bank <= '0;
    end else begin
      illegal      <= |bad;
      illegal_bank <= sel;
    end
  end
endmodule

// File: rtl/sdram_bank_tracker_checks.sv
module sdram_bank_tracker_checks #(
  parameter int BA_W = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cke,
  input logic                   cs_n,
  input logic                   ras_n,
  input logic                   cas_n,
  input logic                   we_n,
  input logic [BA_W-1:0]        ba,
  input logic                   illegal,
  input logic [BA_W-1:0]        illegal_bank,
  input logic [3*(1<<BA_W)-1:0] bank_state
);
  logic ck_q;
  always_ff @(posedge clk)
    if (!rst_n) ck_q <= 1'b1;
    else        ck_q <= cke;

  assert_nop_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || {ras_n, cas_n, we_n} == 3'b111) |=> !illegal);

  assert_cke_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> !illegal);

  assert_stop_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_q && cke && !cs_n && {ras_n, cas_n, we_n} == 3'b110 && bank_state[3*ba +: 3] == 3'd2)
    |=> (illegal && illegal_bank == $past(ba) && bank_state[3*$past(ba) +: 3] == 3'd2));

  for (genvar b = 0; b < (1 << BA_W); b++) begin : g_chk
    assert_opening_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bank_state[3*b +: 3] == 3'd1 |=> bank_state[3*b +: 3] inside {3'd1, 3'd2});
    assert_closing_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bank_state[3*b +: 3] == 3'd5 |=> bank_state[3*b +: 3] inside {3'd5, 3'd0});
    assert_autoclose_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bank_state[3*b +: 3] == 3'd6 |=> bank_state[3*b +: 3] inside {3'd6, 3'd0});
  end
endmodule

bind sdram_bank_tracker sdram_bank_tracker_checks #(.BA_W(BA_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .ba(ba), .illegal(illegal), .illegal_bank(illegal_bank),
  .bank_state(bank_state)
);

// File: tb/sdram_bank_tracker_bench.sv
`timescale 1ns/1ps
module sdram_bank_tracker_bench;
  localparam int T_RCD = 3, T_RP = 3, T_XSR = 8, BL = 4;
  localparam logic [2:0] NOP = 3'b111, ACT = 3'b011, REF = 3'b001, LMR = 3'b000,
                         PRE = 3'b010, RD = 3'b101, WR = 3'b100, BST = 3'b110;

  logic clk = 0, rst_n = 0, cke = 1, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1, a10 = 0;
  logic [1:0] ba = 0;
  logic illegal;
  logic [1:0] illegal_bank;
  logic [11:0] bank_state;

  sdram_bank_tracker #(.T_RCD(T_RCD), .T_RP(T_RP), .T_XSR(T_XSR), .BURST_LEN(BL), .BA_W(2))
    u_sdram_bank_tracker (.clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10), .illegal(illegal),
      .illegal_bank(illegal_bank), .bank_state(bank_state));

  always #4 clk = ~clk;

  int vectors = 0, miscompares = 0;
  string tag = "R13";
  longint n = 0;
  int m_st[4];
  longint m_until[4];
  longint xs_until = 0;
  bit ck_prev = 1;
  bit exp_ill;
  int exp_bank;

  function automatic int after_timer(int s);
    return (s == 1 || s == 3 || s == 4) ? 2 : 0;
  endfunction

  function automatic bit timed(int s);
    return s != 0 && s != 2;
  endfunction

  function automatic bit allowed(int s, logic [2:0] c);
    case (s)
      0: return c == ACT || c == REF || c == LMR || c == PRE;
      2: return c == RD || c == WR || c == PRE;
      3, 4: return c == RD || c == WR || c == PRE || c == BST;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [2:0] c;
    bit run, blocked;
    n++;
    c = {ras_n, cas_n, we_n};
    if (!rst_n) begin
      foreach (m_st[b]) begin m_st[b] = 0; m_until[b] = 0; end
      ck_prev = 1; xs_until = 0; exp_ill = 0; exp_bank = 0;
    end else begin
      foreach (m_st[b]) if (timed(m_st[b]) && n >= m_until[b]) m_st[b] = after_timer(m_st[b]);
      run = ck_prev && cke;
      blocked = n < xs_until;
      if (!ck_prev && cke) xs_until = n + T_XSR;
      ck_prev = cke;
      exp_ill = 0; exp_bank = 0;
      if (run && !cs_n && c != NOP) begin
        for (int b = 0; b < 4; b++) begin
          if (b == ba || (c == PRE && a10)) begin
            if (blocked || !allowed(m_st[b], c)) begin
              if (!exp_ill) exp_bank = b;
              exp_ill = 1;
            end else if (c == ACT) begin
              m_st[b] = 1; m_until[b] = n + T_RCD;
            end else if (c == PRE && m_st[b] != 0) begin
              m_st[b] = 5; m_until[b] = n + T_RP;
            end else if (c == RD || c == WR) begin
              m_st[b] = a10 ? (c == RD ? 6 : 7) : (c == RD ? 3 : 4);
              m_until[b] = a10 ? n + BL + T_RP : n + BL;
            end else if (c == BST) begin
              m_st[b] = 2;
            end
          end
        end
      end
    end
    #2;
    vectors++;
    if (illegal !== exp_ill || (exp_ill && illegal_bank !== 2'(exp_bank))) begin
      miscompares++;
      $display("FAIL %s cycle %0d: illegal/bank actual %b/%0d expected %b/%0d",
               tag, n, illegal, illegal_bank, exp_ill, exp_bank);
    end
    for (int b = 0; b < 4; b++) begin
      int d;
      d = (rst_n && timed(m_st[b]) && n + 1 >= m_until[b]) ? after_timer(m_st[b]) : m_st[b];
      if (bank_state[3*b +: 3] !== 3'(d)) begin
        miscompares++;
        $display("FAIL %s R14 cycle %0d bank %0d: state actual %0d expected %0d",
                 tag, n, b, bank_state[3*b +: 3], d);
      end
    end
  end

  task automatic issue(input logic [2:0] c, input int b, input bit a = 0, input bit sel_n = 0);
    @(negedge clk);
    cs_n = sel_n; {ras_n, cas_n, we_n} = c; ba = 2'(b); a10 = a;
  endtask

  task automatic idle(input int k);
    repeat (k) issue(NOP, 0);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #1600000;
    miscompares++;
    $display("FAIL watchdog expired, actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R13"; idle(2);
    tag = "R1";  issue(RD, 0, 0, 1); issue(ACT, 1, 0, 1); issue(NOP, 2); idle(1);
    tag = "R3";  issue(RD, 0); issue(BST, 0); issue(WR, 0); issue(PRE, 0); issue(REF, 0);
                 issue(LMR, 0); idle(1);
    tag = "R4";  issue(ACT, 1); issue(RD, 1); idle(T_RCD - 3); issue(RD, 1); idle(1);
                 issue(ACT, 0); idle(T_RCD - 2); issue(RD, 0);
    tag = "R5";  idle(2); issue(BST, 0); issue(ACT, 0); issue(LMR, 0); issue(REF, 0);
    tag = "R6";  issue(RD, 0); issue(BST, 0); issue(WR, 0); issue(RD, 0); idle(BL - 1);
                 issue(BST, 0); issue(WR, 0); idle(BL); issue(BST, 0);
    tag = "R7";  issue(RD, 0); issue(PRE, 0); idle(T_RP - 2); issue(ACT, 0); issue(ACT, 0);
                 idle(T_RCD);
    tag = "R8";  issue(RD, 0, 1); idle(BL + T_RP - 2); issue(ACT, 0); issue(ACT, 0);
                 idle(T_RCD); issue(WR, 0, 1); idle(BL + T_RP - 1); issue(REF, 0);
    tag = "R9";  issue(ACT, 2); issue(PRE, 2); issue(ACT, 2); idle(T_RCD);
    tag = "R10"; issue(ACT, 3); issue(PRE, 0, 1); idle(T_RCD); issue(PRE, 0, 1); idle(T_RP);
                 issue(ACT, 1); issue(ACT, 2); idle(1); issue(PRE, 0, 1); idle(T_RP);
    tag = "R2";  issue(ACT, 0); idle(T_RCD);
                 @(negedge clk); cke = 0; issue(BST, 0); issue(ACT, 0); issue(LMR, 0);
    tag = "R11"; @(negedge clk); cke = 1; cs_n = 0; {ras_n, cas_n, we_n} = BST;
                 issue(RD, 0); idle(T_XSR - 3); issue(BST, 0); issue(BST, 0);
                 issue(PRE, 0); idle(T_RP);
    tag = "R12"; issue(RD, 1); issue(RD, 1); issue(ACT, 1); idle(T_RCD);
    tag = "R12";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 3) begin @(negedge clk); cke = ~cke; end
      else issue(3'($urandom), int'($urandom_range(0, 3)), bit'($urandom_range(0, 3) == 0),
                 bit'($urandom_range(0, 5) == 0));
    end
    @(negedge clk); cke = 1;
    idle(20);
    finish_run();
  end
endmodule